// File: doc/BRIEF.md
# Round-Robin Ingress FIFO Arbiter

This block decides which of several per-port ingress FIFOs may move its next frame onto a single shared internal bus. Each port raises a frame-ready level when it holds a complete frame. The arbiter grants exactly one port at a time and reports the grant both as an index and as a one-hot vector. The index drives the pop select of the shared bus. A grant is held until the forwarding datapath pulses a frame-done signal.

Fairness comes from a round-robin start pointer. The search for the next grant begins at the port after the one most recently served and wraps at the configured port count. The port count is a parameter and does not have to be a power of two. The default is fifteen ports, numbered 0 to 14. The selection path is timing-critical, so the scan result passes through one register stage before it becomes a grant.

Top module: `ingress_rr_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, no grant is asserted. The start pointer resets to port 0, so if every port requests, the first grant goes to port 0.
- R2: At most one grant is active at a time. While `grant_valid` is high, `grant_onehot` has exactly the bit at position `grant_idx` set (bit i stands for port i). While it is low, `grant_onehot` is all zeros.
- R3: A new grant goes to the first requesting port in circular order. The order starts at the port after the last one granted.
- R4: The start pointer wraps modulo NUM_PORTS. After port NUM_PORTS-1 has been served, the search restarts at port 0. `grant_idx` is never NUM_PORTS or above.
- R5: Once given, a grant and its index stay unchanged until `frame_done` is sampled high. The grant is then withdrawn at that same clock edge.
- R6: `frame_done` sampled while no grant is active has no effect: no grant appears and the start pointer does not move.
- R7: With no port requesting, the arbiter stays idle and asserts no grant.
- R8: Requests are scanned into a register first. With the arbiter idle, a held request yields a grant on the second rising edge after it is first sampled, and never on the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_rdy | input | NUM_PORTS | Per-port level: the FIFO holds a frame to forward |
| frame_done | input | 1 | Pulse from the datapath: the granted frame has been transferred |
| grant_valid | output | 1 | A port currently owns the shared bus |
| grant_idx | output | $clog2(NUM_PORTS) | Index of the granted port |
| grant_onehot | output | NUM_PORTS | One-hot form of the grant, bit i for port i |

## Verification
The assertions rely on two properties of the inputs. First, a port that is not currently granted keeps its frame-ready level steady while the arbiter is idle. This matters because the registered pick stage must still point at a requesting port when the grant is issued. Second, `frame_done` is a single-cycle pulse. The stimulus respects both: request vectors change only on the cycle the arbiter releases a grant or while it is idle with nothing requested, and every done pulse is driven for exactly one cycle. Random request vectors are mixed with directed cases for the wrap past the last port, empty requests and stray done pulses.

// File: rtl/ingress_arb_pkg.sv
// Package: shared types and helpers for the ingress round-robin arbiter.
// Assumes: port counts of at least two.
package ingress_arb_pkg;

    // Control state of the grant machine.
    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    // Width of a port index for a given port count.
    function automatic int port_idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rr_search.sv
// Module: rr_search
// Finds the first requesting port in circular order, starting at start_idx.
// Purely combinational. Assumes start_idx < NUM_PORTS.
module rr_search #(
    parameter int NUM_PORTS = 15,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_PORTS-1:0] req,
    input  logic [IDX_W-1:0]     start_idx,
    output logic                 found,
    output logic [IDX_W-1:0]     pick_idx
);

    // Scan offsets from the far end down, so the nearest requester wins.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = NUM_PORTS - 1; k >= 0; k--) begin
            int p;
            p = int'(start_idx) + k;
            if (p >= NUM_PORTS) begin
                p = p - NUM_PORTS;
            end
            if (req[p]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(p);
            end
        end
    end

endmodule

// File: rtl/rr_pointer.sv
// Module: rr_pointer
// Holds the round-robin start index. On advance it moves to the port after
// last_idx, wrapping explicitly at NUM_PORTS (not at a power of two).
// Assumes last_idx < NUM_PORTS whenever advance is high.
module rr_pointer #(
    parameter int NUM_PORTS = 15,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] start_idx
);

    localparam logic [IDX_W-1:0] LAST_PORT = IDX_W'(NUM_PORTS - 1);

    // Register the start index; wrap past the final port back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_idx <= '0;
        end else if (advance) begin
            start_idx <= (last_idx == LAST_PORT) ? '0 : last_idx + 1'b1;
        end
    end

    // The start index never leaves the legal port range (wrap rule).
    assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_idx < IDX_W'(NUM_PORTS));

    // After serving the final port, the search restarts at port 0.
    assert_ptr_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && last_idx == LAST_PORT) |=> (start_idx == '0));

endmodule

// File: rtl/arb_ctrl.sv
// Module: arb_ctrl
// Registers the search result (pipeline stage), issues a grant from it while
// idle, holds the grant in the busy state until frame_done, then asks the
// pointer to advance. Assumes frame_done is a one-cycle pulse and that
// requests of ungranted ports stay steady while idle.
module arb_ctrl
    import ingress_arb_pkg::*;
#(
    parameter int NUM_PORTS = 15,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             found,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             frame_done,
    output logic             advance,
    output logic [IDX_W-1:0] last_idx,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_idx
);

    arb_state_e       state_q;
    logic             pick_vld_q;
    logic [IDX_W-1:0] pick_idx_q;

    // Pipeline stage: capture the scan only while idle, clear it while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_vld_q <= 1'b0;
            pick_idx_q <= '0;
        end else if (state_q == ARB_IDLE) begin
            pick_vld_q <= found;
            pick_idx_q <= pick_idx;
        end else begin
            pick_vld_q <= 1'b0;
        end
    end

    // Grant state machine: idle -> busy on a registered pick, busy -> idle on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ARB_IDLE;
            grant_idx <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (pick_vld_q) begin
                        state_q   <= ARB_BUSY;
                        grant_idx <= pick_idx_q;
                    end
                end
                ARB_BUSY: begin
                    if (frame_done) begin
                        state_q <= ARB_IDLE;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    // Outputs toward the pointer and the shared bus select.
    always_comb begin
        grant_valid = (state_q == ARB_BUSY);
        advance     = grant_valid && frame_done;
        last_idx    = grant_idx;
    end

    // A held grant keeps its index until done arrives.
    assert_grant_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !frame_done) |=> (grant_valid && $stable(grant_idx)));

    // Done while granted withdraws the grant at once.
    assert_grant_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && frame_done) |=> !grant_valid);

    // Done while idle cannot start a grant by itself.
    assert_idle_done_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && !pick_vld_q) |=> !grant_valid);

    // The granted index stays below the port count.
    assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_idx < IDX_W'(NUM_PORTS)));

endmodule

// File: rtl/ingress_rr_arbiter.sv
// Module: ingress_rr_arbiter (top)
// Round-robin arbiter choosing which ingress FIFO is popped onto the shared
// bus. Search -> registered pick -> busy/done grant -> pointer advance.
// Assumes frame_rdy of ungranted ports is steady while idle and that
// frame_done is a single-cycle pulse.
module ingress_rr_arbiter
    import ingress_arb_pkg::*;
#(
    parameter int NUM_PORTS = 15,
    localparam int IDX_W    = port_idx_width(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] frame_rdy,
    input  logic                 frame_done,
    output logic                 grant_valid,
    output logic [IDX_W-1:0]     grant_idx,
    output logic [NUM_PORTS-1:0] grant_onehot
);

    logic             srch_found;
    logic [IDX_W-1:0] srch_idx;
    logic [IDX_W-1:0] start_idx;
    logic             ptr_advance;
    logic [IDX_W-1:0] ptr_last;

    rr_search #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_search (
        .req       (frame_rdy),
        .start_idx (start_idx),
        .found     (srch_found),
        .pick_idx  (srch_idx)
    );

    arb_ctrl #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .found       (srch_found),
        .pick_idx    (srch_idx),
        .frame_done  (frame_done),
        .advance     (ptr_advance),
        .last_idx    (ptr_last),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    rr_pointer #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (ptr_advance),
        .last_idx  (ptr_last),
        .start_idx (start_idx)
    );

    // Decode the granted index into one select line per port.
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_onehot
        assign grant_onehot[i] = grant_valid && (grant_idx == IDX_W'(i));
    end

    // At most one select line; exactly one while a grant is active.
    assert_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_onehot));
    assert_onehot_when_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ($countones(grant_onehot) == 1));

    // A fresh grant targets a port that was requesting on the previous cycle.
    assert_grant_to_requester_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (($past(frame_rdy) >> grant_idx) & 1) != 0);

    // Two idle cycles with nothing requested leave no grant behind.
    assert_no_req_no_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && frame_rdy == '0) |=> (!grant_valid && frame_rdy == '0) |=> !grant_valid);

endmodule

// File: tb/ingress_rr_arbiter_bench.sv
// Bench: directed corner cases plus seeded random request vectors, checked
// against a circular-order model of the arbiter.
module ingress_rr_arbiter_bench;

    localparam int N  = 15;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  frame_rdy = '0;
    logic          frame_done = 1'b0;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;
    logic [N-1:0]  grant_onehot;

    int checks = 0;
    int fails  = 0;
    int exp_ptr = 0;
    int cycles = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ingress_rr_arbiter #(.NUM_PORTS(N)) u_ingress_rr_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_rdy    (frame_rdy),
        .frame_done   (frame_done),
        .grant_valid  (grant_valid),
        .grant_idx    (grant_idx),
        .grant_onehot (grant_onehot)
    );

    // Model: first requester at or after the start pointer, circularly.
    function automatic int exp_pick(input logic [N-1:0] r, input int s);
        for (int k = 0; k < N; k++) begin
            int p;
            p = (s + k) % N;
            if (r[p]) return p;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Caller is at a negedge with the arbiter idle and its pick stage empty.
    task automatic run_frame(input logic [N-1:0] r, input int hold);
        int e;
        frame_rdy = r;
        e = exp_pick(r, exp_ptr);
        @(negedge clk);
        check(!grant_valid, "R8", "grant after one edge", grant_valid, 0);
        @(negedge clk);
        check(grant_valid, "R8", "grant after two edges", grant_valid, 1);
        check(int'(grant_idx) == e, "R3", "granted index", grant_idx, e);
        check(grant_onehot == (N'(1) << e), "R2", "one-hot grant", grant_onehot, N'(1) << e);
        check(int'(grant_idx) < N, "R4", "index range", grant_idx, N - 1);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(grant_valid && int'(grant_idx) == e, "R5", "grant held", grant_idx, e);
        end
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        check(!grant_valid && grant_onehot == '0, "R5", "release on done", grant_valid, 0);
        exp_ptr = (e + 1) % N;
    endtask

    // Caller is at a negedge with the arbiter idle.
    task automatic idle_check(input int n, input bit stray_done);
        frame_rdy = '0;
        for (int i = 0; i < n; i++) begin
            frame_done = stray_done && (i == 1);
            @(negedge clk);
            check(!grant_valid && grant_onehot == '0,
                  stray_done ? "R6" : "R7", "no grant while idle", grant_valid, 0);
        end
        frame_done = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            fails++;
            $display("FAIL R5 watchdog expired: actual %0d expected %0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0;
        frame_rdy = '1;
        repeat (3) @(negedge clk);
        check(!grant_valid && grant_onehot == '0, "R1", "no grant in reset", grant_valid, 0);
        frame_rdy = '0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!grant_valid, "R1", "no grant after reset", grant_valid, 0);

        // R1: every port requesting, the first grant is port 0.
        run_frame('1, 0);
        // R3: sweep with all requesting walks 1, 2, 3.
        run_frame('1, 1);
        run_frame('1, 2);
        run_frame('1, 0);
        // R3: a lower requester only wins after wrapping.
        run_frame(N'(1) << 2 | N'(1) << 9, 0);
        // R4: serve the last port, then the search restarts at 0.
        run_frame(N'(1) << (N - 1), 1);
        run_frame('1, 0);
        check(exp_ptr == 1, "R4", "pointer after wrap", exp_ptr, 1);
        // R4: last port again, then only port 13 and port 0 requesting.
        run_frame(N'(1) << (N - 1), 0);
        run_frame(N'(1) << 13 | N'(1), 0);
        // R7: nothing requesting.
        idle_check(5, 1'b0);
        // R6: stray done while idle, then pointer unchanged (still 1).
        idle_check(4, 1'b1);
        run_frame('1, 0);

        // Random request vectors and hold lengths.
        for (int t = 0; t < 400; t++) begin
            logic [N-1:0] r;
            r = N'($urandom) & N'($urandom);
            if (r == '0) idle_check(2, t[0]);
            else run_frame(r, int'($urandom_range(0, 3)));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule